// File: doc/BRIEF.md
# PCI Host Bridge CPU-Side Address Translator

This block sits on the processor side of a PCI host bridge and sorts every CPU access into one of the bridge's downstream targets. For each request it reports which target the access goes to. It also reports the address that target sees. The result is registered, so it appears one clock after the request.

The targets are I/O space, memory space, a configuration direct-map window, the two configuration port registers, an interrupt-acknowledge location and the boot ROM. An access that matches none of them is reported as unmapped. The I/O mapping follows a level input. When it is low, I/O uses a dense 64 KB map. When it is high, the first 8 MB of I/O is folded so that each 4 KB page carries 32 bytes of port space.

In the configuration window, a one-hot select field in the address becomes a device number. An interrupt-acknowledge read raises a strobe toward an external interrupt controller and returns the vector that controller presents.

Top module: `pci_hb_xlate`

## Requirements
- R1: While rst_ni is low and after reset, rsp_valid_o and iack_req_o are 0, and rsp_tgt_o, rsp_addr_o and rsp_rdata_o are 0.
- R2: rsp_valid_o equals req_valid_i of the previous cycle. In a cycle after an idle request, every response output is 0. Target codes are: 0 unmapped, 1 I/O, 2 memory, 3 configuration direct map, 4 configuration index port, 5 configuration data port, 6 interrupt acknowledge, 7 boot ROM.
- R3: With io_mode_i low, an address in 0x80000000..0x807FFFFF gives an I/O target whose downstream address is the offset from 0x80000000 masked to its low 16 bits.
- R4: With io_mode_i high, an address in 0x80000000..0x807FFFFF gives an I/O target. Its downstream address is the offset's bits 4:0, with the offset's bits 22:12 placed at bits 15:5. Offset bits 11:5 are dropped.
- R5: An address in 0x80C00000..0xBF7FFFFF gives an I/O target whose downstream address is the full offset from 0x80000000, in either mode.
- R6: An address in 0x80800000..0x80BFFFFF gives target 3 in either mode. The downstream address carries offset bits 10:0 and, at bits 14:11, the position (0..10) of the lowest set bit among offset bits 21:11. When none of those bits is set, bits 14:11 are 11.
- R7: An I/O access whose translated address falls in 0xCF8..0xCFB gives target 4. One that falls in 0xCFC..0xCFF gives target 5. In both cases the downstream address is the translated I/O address.
- R8: An address in 0xC0000000..0xFEFFFFFF gives target 2, with the downstream address equal to the address minus 0xC0000000.
- R9: An address at or above 0xFFF00000 gives target 7, with the downstream address equal to the address minus 0xFFF00000.
- R10: A one-byte access to 0xBFFFFFF0 gives target 6 with downstream address 0. A read pulses iack_req_o for one cycle alongside the response and returns iack_vec_i, as sampled with the request, in rsp_rdata_o[7:0]. A write raises no strobe and returns 0.
- R11: Any other address gives target 0 and downstream address 0. So do an interrupt-acknowledge access wider than one byte and any request with size code 3. Size codes are 0 for one byte, 1 for two bytes and 2 for four bytes. An unmapped read returns 0xFFFFFFFF; an unmapped write returns 0. Every mapped target other than a vector read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_addr_i | input | 32 | CPU byte address |
| req_size_i | input | 2 | Access size code (0:1 B, 1:2 B, 2:4 B) |
| req_we_i | input | 1 | 1 for write, 0 for read |
| io_mode_i | input | 1 | I/O map level: 0 dense, 1 folded |
| iack_vec_i | input | 8 | Vector offered by the interrupt controller |
| rsp_valid_o | output | 1 | Response valid |
| rsp_tgt_o | output | 3 | Target code |
| rsp_addr_o | output | 32 | Translated downstream address |
| rsp_rdata_o | output | 32 | Locally produced read data |
| iack_req_o | output | 1 | Interrupt-acknowledge strobe |

## Verification
The bench aims at the window edges: the last byte of the folded I/O range next to the first configuration byte, the top of memory space next to the hole below the ROM, and the single interrupt-acknowledge byte with its neighbours. A design with an off-by-one bound would hand such an address to the wrong target or report it as unmapped.

For the configuration window, the bench drives the case with no select bit set and the case with several select bits set. A wrong encoder would report 0 or the highest set bit instead of 11 or the lowest.

The bench also reaches the port registers through both I/O maps. It flips the mode level between back-to-back requests, to catch a folding that drops or keeps the wrong bits. It checks that writes to the acknowledge location never raise the strobe.

// File: rtl/pci_hb_pkg.sv
package pci_hb_pkg;

  typedef enum logic [2:0] {
    TGT_NONE    = 3'd0,
    TGT_IO      = 3'd1,
    TGT_MEM     = 3'd2,
    TGT_CFG     = 3'd3,
    TGT_CFG_IDX = 3'd4,
    TGT_CFG_DAT = 3'd5,
    TGT_IACK    = 3'd6,
    TGT_ROM     = 3'd7
  } tgt_e;

  localparam int unsigned ADDR_W    = 32;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned VEC_W     = 8;

  localparam logic [31:0] IO_BASE   = 32'h8000_0000;
  localparam logic [31:0] IO_SPAN   = 32'h3F80_0000;
  localparam logic [31:0] CFG_BASE  = 32'h8080_0000;
  localparam logic [31:0] CFG_SPAN  = 32'h0040_0000;
  localparam logic [31:0] MEM_BASE  = 32'hC000_0000;
  localparam logic [31:0] MEM_SPAN  = 32'h3F00_0000;
  localparam logic [31:0] IACK_ADDR = 32'hBFFF_FFF0;
  localparam logic [31:0] ROM_BASE  = 32'hFFF0_0000;

  localparam int unsigned IO_OFF_W  = $clog2(IO_SPAN);
  localparam int unsigned CFG_OFF_W = $clog2(CFG_SPAN);
  localparam int unsigned ROM_OFF_W = $clog2(32'hFFFF_FFFF - ROM_BASE);

  localparam logic [15:0] CFG_IDX_PORT = 16'h0CF8;
  localparam logic [15:0] CFG_DAT_PORT = 16'h0CFC;

  typedef struct packed {
    tgt_e              tgt;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] rdata;
    logic              iack;
  } xlate_t;

endpackage

// File: rtl/pci_hb_cfg_enc.sv
module pci_hb_cfg_enc #(
  parameter int unsigned SEL_W = 11,
  parameter int unsigned LOW_W = 11,
  localparam int unsigned IDX_W = $clog2(SEL_W + 1),
  localparam int unsigned OUT_W = IDX_W + LOW_W
) (
  input  logic [SEL_W+LOW_W-1:0] off_i,
  output logic [OUT_W-1:0]       cfg_addr_o
);

  logic [IDX_W-1:0] idx;

  // lowest set select bit wins; none set yields SEL_W
  always_comb begin
    idx = IDX_W'(SEL_W);
    for (int i = SEL_W - 1; i >= 0; i--) begin
      if (off_i[LOW_W+i]) idx = IDX_W'(i);
    end
  end

  assign cfg_addr_o = {idx, off_i[LOW_W-1:0]};

endmodule

// File: rtl/pci_hb_io_fold.sv
module pci_hb_io_fold #(
  parameter int unsigned OFF_W    = 30,
  parameter int unsigned NC_W     = 23,
  parameter int unsigned LO_W     = 5,
  parameter int unsigned HI_LSB   = 12,
  parameter int unsigned CONTIG_W = 16,
  localparam int unsigned HI_MSB  = NC_W - 1,
  localparam int unsigned FOLD_W  = HI_MSB - HI_LSB + 1 + LO_W
) (
  input  logic [OFF_W-1:0] off_i,
  input  logic             nc_mode_i,
  output logic [OFF_W-1:0] io_addr_o
);

  logic             in_low;
  logic [FOLD_W-1:0] folded;

  assign in_low = (off_i[OFF_W-1:NC_W] == '0);
  assign folded = {off_i[HI_MSB:HI_LSB], off_i[LO_W-1:0]};

  always_comb begin
    if (!in_low)        io_addr_o = off_i;
    else if (nc_mode_i) io_addr_o = OFF_W'(folded);
    else                io_addr_o = OFF_W'(off_i[CONTIG_W-1:0]);
  end

endmodule

// File: rtl/pci_hb_win_dec.sv
module pci_hb_win_dec
  import pci_hb_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic              we_i,
  input  logic              nc_mode_i,
  input  logic [VEC_W-1:0]  vec_i,
  output xlate_t            res_o
);

  localparam int unsigned CFG_SEL_W = CFG_OFF_W - 11;
  localparam int unsigned CFG_OUT_W = $clog2(CFG_SEL_W + 1) + 11;

  logic [IO_OFF_W-1:0]  io_off, io_addr;
  logic [CFG_OFF_W-1:0] cfg_off;
  logic [CFG_OUT_W-1:0] cfg_addr;
  logic [ROM_OFF_W-1:0] rom_off;
  logic size_ok, hit_iack, hit_rom, hit_mem, hit_cfg, hit_io;
  logic port_idx, port_dat;

  assign io_off  = IO_OFF_W'(addr_i - IO_BASE);
  assign cfg_off = CFG_OFF_W'(addr_i - CFG_BASE);
  assign rom_off = ROM_OFF_W'(addr_i - ROM_BASE);

  pci_hb_cfg_enc #(
    .SEL_W(CFG_SEL_W),
    .LOW_W(11)
  ) u_cfg_enc (
    .off_i     (cfg_off),
    .cfg_addr_o(cfg_addr)
  );

  pci_hb_io_fold #(
    .OFF_W   (IO_OFF_W),
    .NC_W    (23),
    .LO_W    (5),
    .HI_LSB  (12),
    .CONTIG_W(16)
  ) u_io_fold (
    .off_i    (io_off),
    .nc_mode_i(nc_mode_i),
    .io_addr_o(io_addr)
  );

  assign size_ok  = (size_i != 2'd3);
  assign hit_iack = (addr_i == IACK_ADDR);
  assign hit_rom  = (addr_i >= ROM_BASE);
  assign hit_mem  = (addr_i >= MEM_BASE) && (addr_i < MEM_BASE + MEM_SPAN);
  assign hit_cfg  = (addr_i >= CFG_BASE) && (addr_i < CFG_BASE + CFG_SPAN);
  assign hit_io   = (addr_i >= IO_BASE)  && (addr_i < IO_BASE + IO_SPAN);
  assign port_idx = (io_addr[IO_OFF_W-1:2] == (IO_OFF_W-2)'(CFG_IDX_PORT >> 2));
  assign port_dat = (io_addr[IO_OFF_W-1:2] == (IO_OFF_W-2)'(CFG_DAT_PORT >> 2));

  // priority: size check, iack byte, rom, memory, cfg window, io
  always_comb begin
    res_o       = '0;
    res_o.tgt   = TGT_NONE;
    if (!size_ok) begin
      res_o.tgt = TGT_NONE;
    end else if (hit_iack) begin
      if (size_i == 2'd0) begin
        res_o.tgt   = TGT_IACK;
        res_o.iack  = !we_i;
        res_o.rdata = we_i ? '0 : DATA_W'(vec_i);
      end
    end else if (hit_rom) begin
      res_o.tgt  = TGT_ROM;
      res_o.addr = ADDR_W'(rom_off);
    end else if (hit_mem) begin
      res_o.tgt  = TGT_MEM;
      res_o.addr = addr_i - MEM_BASE;
    end else if (hit_cfg) begin
      res_o.tgt  = TGT_CFG;
      res_o.addr = ADDR_W'(cfg_addr);
    end else if (hit_io) begin
      res_o.addr = ADDR_W'(io_addr);
      if (port_idx)      res_o.tgt = TGT_CFG_IDX;
      else if (port_dat) res_o.tgt = TGT_CFG_DAT;
      else               res_o.tgt = TGT_IO;
    end
    if (res_o.tgt == TGT_NONE && !we_i) res_o.rdata = '1;
  end

endmodule

// File: rtl/pci_hb_xlate.sv
module pci_hb_xlate
  import pci_hb_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic [31:0] req_addr_i,
  input  logic [1:0]  req_size_i,
  input  logic        req_we_i,
  input  logic        io_mode_i,
  input  logic [7:0]  iack_vec_i,
  output logic        rsp_valid_o,
  output logic [2:0]  rsp_tgt_o,
  output logic [31:0] rsp_addr_o,
  output logic [31:0] rsp_rdata_o,
  output logic        iack_req_o
);

  xlate_t dec, rsp_q;
  logic   valid_q;

  pci_hb_win_dec u_dec (
    .addr_i   (req_addr_i),
    .size_i   (req_size_i),
    .we_i     (req_we_i),
    .nc_mode_i(io_mode_i),
    .vec_i    (iack_vec_i),
    .res_o    (dec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      rsp_q   <= '0;
    end else begin
      valid_q <= req_valid_i;
      rsp_q   <= req_valid_i ? dec : '0;
    end
  end

  assign rsp_valid_o = valid_q;
  assign rsp_tgt_o   = rsp_q.tgt;
  assign rsp_addr_o  = rsp_q.addr;
  assign rsp_rdata_o = rsp_q.rdata;
  assign iack_req_o  = rsp_q.iack;

  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  a_r2_idle_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!rsp_valid_o && rsp_tgt_o == 3'd0 && !iack_req_o));
  a_r3_dense_io_16b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !io_mode_i && req_addr_i >= 32'h8000_0000 && req_addr_i < 32'h8080_0000)
      |=> (rsp_addr_o[31:16] == 16'h0));
  a_r6_cfg_devnum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_tgt_o == 3'd3) |-> (rsp_addr_o[31:15] == '0 && rsp_addr_o[14:11] <= 4'd11));
  a_r9_rom_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_tgt_o == 3'd7) |-> (rsp_addr_o[31:20] == '0));
  a_r10_iack_read_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iack_req_o |-> (rsp_valid_o && rsp_tgt_o == 3'd6 && !$past(req_we_i)));
  a_r11_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_tgt_o == 3'd0) |-> (rsp_addr_o == '0 && !iack_req_o));

endmodule

// File: tb/tb_pci_hb_xlate.sv
`timescale 1ns/1ps
module tb_pci_hb_xlate;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_we = 1'b0;
  logic        io_mode = 1'b0;
  logic [7:0]  iack_vec = '0;
  logic        rsp_valid, iack_req;
  logic [2:0]  rsp_tgt;
  logic [31:0] rsp_addr, rsp_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic        e_valid = 1'b0, e_iack = 1'b0;
  logic [2:0]  e_tgt = '0;
  logic [31:0] e_addr = '0, e_rdata = '0;
  string       e_tag = "R2";

  always #4 clk = ~clk;

  pci_hb_xlate dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .req_valid_i(req_valid),
    .req_addr_i (req_addr),
    .req_size_i (req_size),
    .req_we_i   (req_we),
    .io_mode_i  (io_mode),
    .iack_vec_i (iack_vec),
    .rsp_valid_o(rsp_valid),
    .rsp_tgt_o  (rsp_tgt),
    .rsp_addr_o (rsp_addr),
    .rsp_rdata_o(rsp_rdata),
    .iack_req_o (iack_req)
  );

  task automatic model(input logic [31:0] a, input logic [1:0] sz, input logic we,
                       input logic md, input logic [7:0] vec);
    longint off, io;
    int i;
    e_tgt = 0; e_addr = 0; e_rdata = 0; e_iack = 0; e_tag = "R11";
    if (sz == 2'd3) begin
      e_tgt = 0;
    end else if (a == 32'hBFFF_FFF0) begin
      if (sz == 2'd0) begin
        e_tgt = 6; e_iack = !we; e_rdata = we ? 0 : {24'h0, vec}; e_tag = "R10";
      end
    end else if (a >= 32'hFFF0_0000) begin
      e_tgt = 7; e_addr = a - 32'hFFF0_0000; e_tag = "R9";
    end else if (a >= 32'hC000_0000 && a < 32'hFF00_0000) begin
      e_tgt = 2; e_addr = a - 32'hC000_0000; e_tag = "R8";
    end else if (a >= 32'h8080_0000 && a < 32'h80C0_0000) begin
      off = longint'(a) - 64'h8080_0000;
      i = 11;
      for (int k = 10; k >= 0; k--) if (((off >> (11 + k)) & 1) == 1) i = k;
      e_tgt = 3; e_addr = 32'(off % 2048 + i * 2048); e_tag = "R6";
    end else if (a >= 32'h8000_0000 && a < 32'hBF80_0000) begin
      off = longint'(a) - 64'h8000_0000;
      if (off >= 64'h80_0000) begin io = off; e_tag = "R5"; end
      else if (md) begin io = off % 32 + ((off / 4096) % 2048) * 32; e_tag = "R4"; end
      else begin io = off % 65536; e_tag = "R3"; end
      e_addr = 32'(io);
      if (io / 4 == 64'hCF8 / 4) begin e_tgt = 4; e_tag = "R7"; end
      else if (io / 4 == 64'hCFC / 4) begin e_tgt = 5; e_tag = "R7"; end
      else e_tgt = 1;
    end
    if (e_tgt == 0 && !we) e_rdata = 32'hFFFF_FFFF;
  endtask

  task automatic check_now();
    n_chk++;
    if (rsp_valid !== e_valid || rsp_tgt !== e_tgt || rsp_addr !== e_addr ||
        rsp_rdata !== e_rdata || iack_req !== e_iack) begin
      n_fail++;
      $display("FAIL %s: got v=%0b t=%0d a=%h d=%h i=%0b exp v=%0b t=%0d a=%h d=%h i=%0b",
               e_tag, rsp_valid, rsp_tgt, rsp_addr, rsp_rdata, iack_req,
               e_valid, e_tgt, e_addr, e_rdata, e_iack);
    end
  endtask

  // negedge: check previous response, then apply the next request
  task automatic step(input logic v, input logic [31:0] a, input logic [1:0] sz,
                      input logic we, input logic md, input logic [7:0] vec);
    @(negedge clk);
    check_now();
    req_valid = v; req_addr = a; req_size = sz; req_we = we; io_mode = md; iack_vec = vec;
    if (v) model(a, sz, we, md, vec);
    else begin
      e_tgt = 0; e_addr = 0; e_rdata = 0; e_iack = 0; e_tag = "R2";
    end
    e_valid = v;
  endtask

  initial begin
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      e_tag = "R1";
      check_now();
    end
    rst_n = 1'b1;
    @(negedge clk); e_tag = "R1"; check_now();

    // R3 dense I/O
    step(1, 32'h8000_1234, 0, 0, 0, 0);
    step(1, 32'h807F_FFFF, 2, 1, 0, 0);
    step(1, 32'h8012_3456, 1, 0, 0, 0);
    // R4 folded I/O, mode flips back to back
    step(1, 32'h8012_3456, 1, 0, 1, 0);
    step(1, 32'h807F_FFFF, 2, 0, 1, 0);
    step(1, 32'h8000_0FE0, 0, 1, 1, 0);
    // R5 high I/O
    step(1, 32'h80C0_0000, 2, 0, 1, 0);
    step(1, 32'hBF7F_FFFF, 0, 1, 0, 0);
    // R6 configuration direct map
    step(1, 32'h8080_0000, 2, 0, 0, 0);
    step(1, 32'h8080_0804, 2, 0, 1, 0);
    step(1, 32'h80A0_1FFF, 2, 1, 0, 0);
    step(1, 32'h80BF_F800, 0, 0, 0, 0);
    step(1, 32'h8088_87FC, 2, 0, 0, 0);
    // R7 config ports, both maps
    step(1, 32'h8000_0CF8, 2, 1, 0, 0);
    step(1, 32'h8000_0CFD, 0, 0, 0, 0);
    step(1, 32'h8006_7018, 2, 1, 1, 0);
    step(1, 32'h8006_701C, 2, 0, 1, 0);
    step(1, 32'h8000_0CF8, 2, 0, 1, 0);
    // R8 memory
    step(1, 32'hC000_0000, 2, 0, 0, 0);
    step(1, 32'hFEFF_FFFF, 0, 1, 0, 0);
    // R9 rom
    step(1, 32'hFFF0_0000, 2, 0, 0, 0);
    step(1, 32'hFFFF_FFFF, 0, 0, 0, 0);
    // R10 interrupt acknowledge
    step(1, 32'hBFFF_FFF0, 0, 0, 0, 8'h5A);
    step(1, 32'hBFFF_FFF0, 0, 1, 0, 8'hA5);
    step(1, 32'hBFFF_FFF0, 0, 0, 1, 8'h21);
    // R11 unmapped
    step(1, 32'hBFFF_FFF0, 1, 0, 0, 8'h11);
    step(1, 32'hBFFF_FFEF, 0, 0, 0, 0);
    step(1, 32'hBFFF_FFF1, 0, 1, 0, 0);
    step(1, 32'hBF80_0000, 2, 0, 0, 0);
    step(1, 32'hFF00_0000, 2, 0, 0, 0);
    step(1, 32'hFFEF_FFFF, 0, 1, 0, 0);
    step(1, 32'h7FFF_FFFF, 2, 0, 0, 0);
    step(1, 32'hC000_0000, 3, 0, 0, 0);
    // R2 idle gap
    step(0, 32'hC000_0000, 2, 0, 0, 0);
    step(0, 32'hBFFF_FFF0, 0, 0, 0, 8'h33);

    // mixed patterns across all windows
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] a;
      case ($urandom_range(0, 7))
        0: a = 32'h8000_0000 | ($urandom & 32'h007F_FFFF);
        1: a = 32'h8080_0000 | ($urandom & 32'h003F_FFFF);
        2: a = 32'h8000_0000 + ($urandom % 32'h3F80_0000);
        3: a = 32'hC000_0000 + ($urandom % 32'h3F00_0000);
        4: a = 32'hFFF0_0000 | ($urandom & 32'h000F_FFFF);
        5: a = 32'hBFFF_FFF0 + ($urandom % 3) - 1;
        6: a = 32'h8006_7018 | ($urandom & 32'h7);
        default: a = $urandom;
      endcase
      step($urandom_range(0, 4) != 0, a, 2'($urandom), 1'($urandom),
           1'($urandom), 8'($urandom));
    end
    step(0, 0, 0, 0, 0, 0);
    @(negedge clk); check_now();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule